// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the combinational control unit of a single-cycle 32-bit load/store processor. It sees the 6-bit opcode taken from instruction bits [31:26] and the 6-bit function field taken from bits [5:0]. From these it drives the select and enable lines of the datapath in the same cycle.

Decoding takes place in two levels. The main level turns the opcode into datapath controls and a 2-bit ALU operation class. The ALU level combines that class with the function field to form a 4-bit ALU code.

The block recognises four instruction kinds: register-register arithmetic and logic, load word, store word and branch-if-equal. Any other opcode is treated as inert: it writes no register, touches no memory and takes no branch.

Top module: `sc_ctrl_decode`

## Requirements
- R1: Opcode 000000 (register-register) gives dst_is_rd=1, src_is_imm=0, load_to_reg=0, rf_we=1, dmem_re=0, dmem_we=0, is_branch=0 and alu_class=10.
- R2: Opcode 100011 (load word) gives dst_is_rd=0, src_is_imm=1, load_to_reg=1, rf_we=1, dmem_re=1, dmem_we=0, is_branch=0 and alu_class=00.
- R3: Opcode 101011 (store word) gives src_is_imm=1, dmem_we=1, rf_we=0, dmem_re=0, is_branch=0, dst_is_rd=0, load_to_reg=0 and alu_class=00.
- R4: Opcode 000100 (branch-if-equal) gives is_branch=1, src_is_imm=0, rf_we=0, dmem_re=0, dmem_we=0, dst_is_rd=0, load_to_reg=0 and alu_class=01.
- R5: Any other opcode drives all seven control outputs to 0, alu_class to 00 and alu_code to 0010.
- R6: alu_class 00 always yields alu_code 0010 (add), and alu_class 01 always yields 0110 (subtract).
- R7: Under alu_class 10, the function field selects alu_code as follows: 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (AND), 100101 gives 0001 (OR) and 101010 gives 0111 (set-on-less-than).
- R8: Under alu_class 10, any function field not listed in R7 yields 0010. As a result, bit 3 of alu_code is always 0.
- R9: dmem_re and dmem_we are never high together. rf_we and dmem_we are never high together.
- R10: The outputs depend only on the present opcode and function field. Applying the same inputs a second time gives the same outputs, whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits [31:26] |
| funct | input | 6 | Instruction bits [5:0] |
| dst_is_rd | output | 1 | Write-back register is rd (1) or rt (0) |
| src_is_imm | output | 1 | Second ALU operand is the immediate (1) or a register (0) |
| load_to_reg | output | 1 | Write-back data comes from memory (1) or the ALU (0) |
| rf_we | output | 1 | Register file write enable |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| is_branch | output | 1 | Instruction is a conditional branch |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract, 10 decode the function field |
| alu_code | output | 4 | ALU operation code |

## Verification
Every output is a pure function of the two inputs, so each result is due in the same cycle as the stimulus that produces it, with no register in between. The bench changes the inputs just after a rising clock edge and samples at the following falling edge. That leaves half a period for the logic to settle and keeps every comparison clear of the edge. The bench samples each stimulus exactly once, before it applies the next one, so a stale or late output shows up as a mismatch on that very stimulus.

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       dst_is_rd,
  output logic       src_is_imm,
  output logic       load_to_reg,
  output logic       rf_we,
  output logic       dmem_re,
  output logic       dmem_we,
  output logic       is_branch,
  output logic [1:0] alu_class,
  output logic [3:0] alu_code
);
  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  logic [6:0] ctl;

  always_comb begin
    ctl       = 7'b0;
    alu_class = CLS_ADD;
    case (opcode)
      OP_REG:   begin ctl = 7'b1001000; alu_class = CLS_FN;  end
      OP_LOAD:  begin ctl = 7'b0111100;                      end
      OP_STORE: begin ctl = 7'b0100010;                      end
      OP_BEQ:   begin ctl = 7'b0000001; alu_class = CLS_SUB; end
      default:  begin ctl = 7'b0;                            end
    endcase
  end

  assign {dst_is_rd, src_is_imm, load_to_reg, rf_we, dmem_re, dmem_we, is_branch} = ctl;

  always_comb begin
    case (alu_class)
      CLS_SUB: alu_code = ALU_SUB;
      CLS_FN: begin
        case (funct)
          6'b100010: alu_code = ALU_SUB;
          6'b100100: alu_code = ALU_AND;
          6'b100101: alu_code = ALU_OR;
          6'b101010: alu_code = ALU_SLT;
          default:   alu_code = ALU_ADD;
        endcase
      end
      default: alu_code = ALU_ADD;
    endcase
  end
endmodule

module sc_ctrl_decode_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       rf_we,
  input logic       dmem_re,
  input logic       dmem_we,
  input logic       is_branch,
  input logic [1:0] alu_class,
  input logic [3:0] alu_code
);
  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      assert_mem_excl_R9: assert (!(dmem_re && dmem_we));
      assert_wb_store_excl_R9: assert (!(rf_we && dmem_we));
      assert_code_msb_R8: assert (alu_code[3] == 1'b0);
      assert_class_add_R6: assert (alu_class != 2'b00 || alu_code == 4'b0010);
      assert_class_sub_R6: assert (alu_class != 2'b01 || alu_code == 4'b0110);
      assert_branch_only_beq_R4: assert (!is_branch || opcode == 6'b000100);
      assert_unknown_inert_R5: assert (opcode inside {6'b000000, 6'b000100, 6'b100011, 6'b101011}
                                       || !(rf_we || dmem_re || dmem_we || is_branch));
    end
  end
endmodule

bind sc_ctrl_decode sc_ctrl_decode_chk u_chk (
  .opcode(opcode), .funct(funct), .rf_we(rf_we), .dmem_re(dmem_re), .dmem_we(dmem_we),
  .is_branch(is_branch), .alu_class(alu_class), .alu_code(alu_code)
);

// File: tb/sc_ctrl_decode_bench.sv
module sc_ctrl_decode_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] opcode, funct;
  logic dst_is_rd, src_is_imm, load_to_reg, rf_we, dmem_re, dmem_we, is_branch;
  logic [1:0] alu_class;
  logic [3:0] alu_code;
  int total = 0, bad = 0;
  bit done = 0;

  sc_ctrl_decode u_sc_ctrl_decode (
    .opcode(opcode), .funct(funct), .dst_is_rd(dst_is_rd), .src_is_imm(src_is_imm),
    .load_to_reg(load_to_reg), .rf_we(rf_we), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .is_branch(is_branch), .alu_class(alu_class), .alu_code(alu_code)
  );

  function automatic logic [8:0] exp_main(input logic [5:0] op);
    case (op)
      6'b000000: return {7'b1001000, 2'b10};
      6'b100011: return {7'b0111100, 2'b00};
      6'b101011: return {7'b0100010, 2'b00};
      6'b000100: return {7'b0000001, 2'b01};
      default:   return {7'b0000000, 2'b00};
    endcase
  endfunction

  function automatic logic [3:0] exp_alu(input logic [1:0] cls, input logic [5:0] fn);
    if (cls == 2'b01) return 4'b0110;
    if (cls != 2'b10) return 4'b0010;
    case (fn)
      6'b100000: return 4'b0010;
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b0010;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'b000000: return "R1";
      6'b100011: return "R2";
      6'b101011: return "R3";
      6'b000100: return "R4";
      default:   return "R5";
    endcase
  endfunction

  task automatic apply_check(input logic [5:0] op, input logic [5:0] fn);
    logic [12:0] got, exp;
    logic [8:0] m;
    @(posedge clk); #1;
    opcode = op; funct = fn;
    @(negedge clk);
    m = exp_main(op);
    exp = {m, exp_alu(m[1:0], fn)};
    got = {dst_is_rd, src_is_imm, load_to_reg, rf_we, dmem_re, dmem_we, is_branch, alu_class, alu_code};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s/R6/R7 op=%b fn=%b got=%b exp=%b", tag_of(op), op, fn, got, exp);
    end
    total++;
    if ((dmem_re && dmem_we) || (rf_we && dmem_we) || alu_code[3] !== 1'b0) begin
      bad++;
      $display("FAIL R8/R9 op=%b got re=%b we=%b rfwe=%b code=%b exp exclusive, msb 0",
               op, dmem_re, dmem_we, rf_we, alu_code);
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [4] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100};
    logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    void'($urandom(32'h5EED));
    opcode = 6'b0; funct = 6'b100000;
    // R1..R4 with each listed function field (R6, R7)
    foreach (ops[i]) foreach (fns[j]) apply_check(ops[i], fns[j]);
    // R8: unlisted function fields under register-register
    apply_check(6'b000000, 6'b100111);
    apply_check(6'b000000, 6'b000000);
    apply_check(6'b000000, 6'b111111);
    // R5: unknown opcodes
    apply_check(6'b000010, 6'b100010);
    apply_check(6'b111111, 6'b101010);
    apply_check(6'b100000, 6'b100100);
    // R10: random mix, repeated inputs must reproduce
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op, fn;
      op = ($urandom % 2) ? ops[$urandom % 4] : 6'($urandom);
      fn = ($urandom % 2) ? fns[$urandom % 5] : 6'($urandom);
      apply_check(op, fn);
      if (k % 7 == 0) apply_check(op, fn);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule